// File: doc/BRIEF.md
# Fast Ethernet Transmit Symbol Encoder

This block turns the 4-bit nibble stream from a MAC into the serial line code of a 100 Mbit/s Ethernet port. It produces one code bit per clock, so it runs from a 125 MHz clock. It accepts one nibble every five clocks and raises `nib_strobe` in the clock whose closing edge samples `txd`, `tx_en` and `tx_er`.

Each nibble becomes a 5-bit code group. Frames are wrapped in start and end delimiters, and the gaps between frames are filled with idle groups. The groups are sent most significant bit first.

In copper mode, each code bit is XORed with an 11-bit LFSR key. The result is converted to NRZI and also drives a three-level MLT3 encoder. In fiber mode, the scrambler and the MLT3 stage are bypassed, so the NRZI of the plain code bits leaves on `line_bit`. While a fiber link reports loss of signal detect, the idle groups carry a far-end-fault pattern instead of plain idle.

Top module: `fe_tx_encoder`

## Requirements
- R1: While reset is held and in the first clock after it, `line_bit` is 0, `mlt3_level` is 00 and `nib_strobe` is 0. The code-group register holds an idle group (11111).
- R2: `nib_strobe` is high in exactly one clock of every five, starting with the fifth clock after reset. The inputs are sampled at the closing edge of that clock. The resulting group occupies the next five clocks, most significant bit first.
- R3: During a frame, data nibbles 0..F map to code groups 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101.
- R4: The first nibble taken with `tx_en` high after idle is replaced by 11000. The next group is always 10001, whatever the inputs are.
- R5: The first nibble taken with `tx_en` low during a frame yields 01101. The next group is 00111 and is followed by idle groups. `tx_en` is ignored while the 00111 group is being chosen.
- R6: A data nibble taken with `tx_er` high yields 00100 in place of its data group.
- R7: In copper mode, every code bit is XORed with a key bit. The key is k = s[10] ^ s[8] of an 11-bit register that shifts left by one each clock with k entering at bit 0 (polynomial x^11 + x^9 + 1). The register is seeded with 7FF hex at reset and advances every clock in both modes.
- R8: `line_bit` is NRZI. One clock after a coded bit of 1 it toggles, and after a 0 it holds.
- R9: In copper mode, `mlt3_level` steps through 00, 01, 00, 11 (0, +1, 0, -1) on each coded 1 and holds on each 0. Level 10 never appears, and +1 and -1 are never adjacent.
- R10: In fiber mode, code bits are not scrambled and `mlt3_level` stays 00.
- R11: With fiber mode on and `sig_detect` low, idle groups are replaced by a repeating run of 17 groups: sixteen 11111 groups and then 11110 (84 ones, then a zero). The run always starts at a group boundary. Frames and their delimiters are never altered. The run restarts from its beginning after any group that is not a fault group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txd | input | 4 | Transmit nibble from the MAC |
| tx_en | input | 1 | Frame in progress |
| tx_er | input | 1 | Code the current nibble as an error group |
| fiber_mode | input | 1 | Bypass scrambler and MLT3 |
| sig_detect | input | 1 | Fiber receive signal detect; low requests far-end fault |
| nib_strobe | output | 1 | Inputs are sampled at the end of this clock |
| line_bit | output | 1 | Serial NRZI bit stream |
| mlt3_level | output | 2 | MLT3 level: 00 zero, 01 plus, 11 minus |

## Verification
Most internal faults reach the ports within one clock. The line is NRZI and every later level depends on every earlier bit, so a wrong group, a wrong key bit or a misplaced bit leaves a lasting polarity error on `line_bit` one edge after the bad bit. A corrupted LFSR state also corrupts every following key bit. A framing-state or fault-counter error is visible within one group time (five clocks) of the strobe that chose the wrong group. A wrong MLT3 index is visible on the next coded 1.

// File: rtl/fe_tx_encoder.sv
module fe_tx_encoder #(
  parameter logic [10:0] SCR_SEED   = 11'h7FF,
  parameter int          FAULT_ONES = 84
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] txd,
  input  logic       tx_en,
  input  logic       tx_er,
  input  logic       fiber_mode,
  input  logic       sig_detect,
  output logic       nib_strobe,
  output logic       line_bit,
  output logic [1:0] mlt3_level
);
  localparam int FLT_GROUPS = (FAULT_ONES + 1) / 5;
  localparam int FCW        = $clog2(FLT_GROUPS);
  localparam logic [FCW-1:0] FLT_LAST = FCW'(FLT_GROUPS - 1);

  localparam logic [4:0] G_IDLE = 5'b11111;
  localparam logic [4:0] G_SSD1 = 5'b11000;
  localparam logic [4:0] G_SSD2 = 5'b10001;
  localparam logic [4:0] G_ESD1 = 5'b01101;
  localparam logic [4:0] G_ESD2 = 5'b00111;
  localparam logic [4:0] G_ERR  = 5'b00100;
  localparam logic [4:0] G_FEND = 5'b11110;

  typedef enum logic [1:0] {S_IDLE, S_SSD2, S_DATA, S_ESD2} fr_t;

  logic [2:0]     phase;
  logic [4:0]     sreg;
  logic [4:0]     grp;
  fr_t            st, st_nx;
  logic [FCW-1:0] fcnt;
  logic           flt_sel;
  logic [10:0]    lfsr;
  logic [1:0]     midx;
  logic           key, sbit;

  function automatic logic [4:0] enc4b5b(input logic [3:0] n);
    case (n)
      4'h0: enc4b5b = 5'b11110;  4'h1: enc4b5b = 5'b01001;
      4'h2: enc4b5b = 5'b10100;  4'h3: enc4b5b = 5'b10101;
      4'h4: enc4b5b = 5'b01010;  4'h5: enc4b5b = 5'b01011;
      4'h6: enc4b5b = 5'b01110;  4'h7: enc4b5b = 5'b01111;
      4'h8: enc4b5b = 5'b10010;  4'h9: enc4b5b = 5'b10011;
      4'hA: enc4b5b = 5'b10110;  4'hB: enc4b5b = 5'b10111;
      4'hC: enc4b5b = 5'b11010;  4'hD: enc4b5b = 5'b11011;
      4'hE: enc4b5b = 5'b11100;  default: enc4b5b = 5'b11101;
    endcase
  endfunction

  always_comb begin
    st_nx   = st;
    grp     = G_IDLE;
    flt_sel = 1'b0;
    case (st)
      S_IDLE:
        if (tx_en) begin
          grp   = G_SSD1;
          st_nx = S_SSD2;
        end else if (fiber_mode && !sig_detect) begin
          flt_sel = 1'b1;
          grp     = (fcnt == FLT_LAST) ? G_FEND : G_IDLE;
        end
      S_SSD2: begin
        grp   = G_SSD2;
        st_nx = S_DATA;
      end
      S_DATA:
        if (!tx_en) begin
          grp   = G_ESD1;
          st_nx = S_ESD2;
        end else begin
          grp = tx_er ? G_ERR : enc4b5b(txd);
        end
      default: begin
        grp   = G_ESD2;
        st_nx = S_IDLE;
      end
    endcase
  end

  assign nib_strobe = (phase == 3'd4);
  assign key        = lfsr[10] ^ lfsr[8];
  assign sbit       = fiber_mode ? sreg[4] : (sreg[4] ^ key);
  assign mlt3_level = (fiber_mode || !midx[0]) ? 2'b00 : (midx[1] ? 2'b11 : 2'b01);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= 3'd0;
      sreg     <= G_IDLE;
      st       <= S_IDLE;
      fcnt     <= '0;
      lfsr     <= SCR_SEED;
      line_bit <= 1'b0;
      midx     <= 2'd0;
    end else begin
      phase    <= nib_strobe ? 3'd0 : phase + 3'd1;
      lfsr     <= {lfsr[9:0], key};
      line_bit <= line_bit ^ sbit;
      if (!fiber_mode && sbit) midx <= midx + 2'd1;
      if (nib_strobe) begin
        sreg <= grp;
        st   <= st_nx;
        fcnt <= (flt_sel && fcnt != FLT_LAST) ? fcnt + 1'b1 : '0;
      end else begin
        sreg <= {sreg[3:0], 1'b0};
      end
    end
  end
endmodule

module fe_tx_encoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fiber_mode,
  input logic       nib_strobe,
  input logic       line_bit,
  input logic [1:0] mlt3_level
);
  logic [2:0] ph_c;
  logic       seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_c <= 3'd0;
      seen <= 1'b0;
    end else begin
      ph_c <= (ph_c == 3'd4) ? 3'd0 : ph_c + 3'd1;
      seen <= 1'b1;
    end
  end

  assert_strobe_cadence_R2: assert property (@(posedge clk) disable iff (!rst_n)
    nib_strobe == (ph_c == 3'd4));

  assert_reset_outputs_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !seen |-> (!line_bit && mlt3_level == 2'b00 && !nib_strobe));

  assert_no_bad_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mlt3_level != 2'b10);

  assert_no_plus_to_minus_R9: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    ($past(mlt3_level) == 2'b01) |-> (mlt3_level != 2'b11));

  assert_no_minus_to_plus_R9: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    ($past(mlt3_level) == 2'b11) |-> (mlt3_level != 2'b01));

  assert_mlt3_tracks_nrzi_R8: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    (!fiber_mode && !$past(fiber_mode)) |->
      ((mlt3_level != $past(mlt3_level)) == (line_bit != $past(line_bit))));
endmodule

bind fe_tx_encoder fe_tx_encoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fiber_mode(fiber_mode), .nib_strobe(nib_strobe),
  .line_bit(line_bit), .mlt3_level(mlt3_level)
);

// File: tb/fe_tx_encoder_tb.sv
module fe_tx_encoder_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] txd = 4'h0;
  logic tx_en = 1'b0, tx_er = 1'b0, fiber_mode = 1'b0, sig_detect = 1'b1;
  logic nib_strobe, line_bit;
  logic [1:0] mlt3_level;

  int total = 0, bad = 0, wd = 0;
  string req = "R1";
  logic b_fm = 1'b0, b_sd = 1'b1;

  bit m_q[$];
  logic m_nrzi = 1'b0;
  logic [1:0] m_idx = 2'd0;
  logic [10:0] m_lfsr = 11'h7FF;
  int m_phase = 0, m_st = 0, m_fcnt = 0;

  always #5 clk = ~clk;

  fe_tx_encoder u_dut (
    .clk(clk), .rst_n(rst_n), .txd(txd), .tx_en(tx_en), .tx_er(tx_er),
    .fiber_mode(fiber_mode), .sig_detect(sig_detect), .nib_strobe(nib_strobe),
    .line_bit(line_bit), .mlt3_level(mlt3_level)
  );

  function automatic logic [4:0] code_of(input logic [3:0] n);
    logic [4:0] t [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101, 5'b01010, 5'b01011,
                           5'b01110, 5'b01111, 5'b10010, 5'b10011, 5'b10110, 5'b10111,
                           5'b11010, 5'b11011, 5'b11100, 5'b11101};
    return t[n];
  endfunction

  function automatic logic [1:0] lvl(input logic [1:0] i);
    return (i == 2'd1) ? 2'b01 : (i == 2'd3) ? 2'b11 : 2'b00;
  endfunction

  task automatic chk(input string what, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s got=%0d exp=%0d", req, what, got, exp);
    end
  endtask

  task automatic step(input logic en, input logic er, input logic [3:0] d, output bit took);
    logic [4:0] g;
    logic cb, k, s;
    chk("line_bit", line_bit, m_nrzi);
    chk("mlt3_level", mlt3_level, fiber_mode ? 0 : lvl(m_idx));
    chk("nib_strobe", nib_strobe, m_phase == 4);
    fiber_mode = b_fm;
    sig_detect = b_sd;
    took = 0;
    cb = m_q.pop_front();
    k = m_lfsr[10] ^ m_lfsr[8];
    s = b_fm ? cb : cb ^ k;
    m_nrzi ^= s;
    if (!b_fm && s) m_idx++;
    m_lfsr = {m_lfsr[9:0], k};
    if (m_phase == 4) begin
      tx_en = en; tx_er = er; txd = d; took = 1;
      g = 5'b11111;
      case (m_st)
        0: if (en) begin g = 5'b11000; m_st = 1; m_fcnt = 0; end
           else if (b_fm && !b_sd) begin
             g = (m_fcnt == 16) ? 5'b11110 : 5'b11111;
             m_fcnt = (m_fcnt == 16) ? 0 : m_fcnt + 1;
           end else m_fcnt = 0;
        1: begin g = 5'b10001; m_st = 2; m_fcnt = 0; end
        2: begin
             m_fcnt = 0;
             if (!en) begin g = 5'b01101; m_st = 3; end
             else g = er ? 5'b00100 : code_of(d);
           end
        default: begin g = 5'b00111; m_st = 0; m_fcnt = 0; end
      endcase
      for (int i = 4; i >= 0; i--) m_q.push_back(g[i]);
      m_phase = 0;
    end else m_phase++;
    @(negedge clk);
  endtask

  task automatic nib(input logic en, input logic er, input logic [3:0] d);
    bit took = 0;
    while (!took) step(en, er, d, took);
  endtask

  task automatic frame(input int n, input logic [3:0] base, input int err_at);
    nib(1, 0, 4'h5);
    nib(1, 0, 4'h5);
    for (int i = 0; i < n; i++) nib(1, i == err_at, base + 4'(i));
    nib(0, 0, 4'h0);
    nib(1, 0, 4'h9);
    nib(0, 0, 4'h0);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      bad++;
      $display("FAIL watchdog expired in %s", req);
      $display("test done: total=%0d bad=%0d", total + 1, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 5; i++) m_q.push_back(1'b1);
    repeat (3) @(negedge clk);
    req = "R1";
    chk("reset line_bit", line_bit, 0);
    chk("reset mlt3_level", mlt3_level, 0);
    chk("reset nib_strobe", nib_strobe, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) nib(0, 0, 4'h0);

    req = "R2/R3/R4/R5/R7/R8/R9";
    frame(16, 4'h0, -1);
    for (int i = 0; i < 4; i++) nib(0, 0, 4'h0);

    req = "R6";
    frame(8, 4'h3, 2);
    frame(3, 4'hC, 0);

    req = "R4/R5 short";
    nib(1, 0, 4'h1);
    nib(0, 0, 4'h2);
    nib(0, 0, 4'h0);
    nib(0, 0, 4'h0);
    nib(1, 0, 4'h7);
    nib(1, 0, 4'h7);
    nib(0, 0, 4'h0);
    nib(0, 0, 4'h0);

    req = "R10";
    b_fm = 1'b1;
    for (int i = 0; i < 3; i++) nib(0, 0, 4'h0);
    frame(16, 4'h8, 5);
    for (int i = 0; i < 3; i++) nib(0, 0, 4'h0);

    req = "R11";
    b_sd = 1'b0;
    for (int i = 0; i < 40; i++) nib(0, 0, 4'h0);
    frame(6, 4'hA, -1);
    for (int i = 0; i < 37; i++) nib(0, 0, 4'h0);
    b_sd = 1'b1;
    for (int i = 0; i < 3; i++) nib(0, 0, 4'h0);
    b_sd = 1'b0;
    for (int i = 0; i < 20; i++) nib(0, 0, 4'h0);

    req = "R7/R9 copper again";
    b_fm = 1'b0;
    b_sd = 1'b1;
    frame(16, 4'h4, 9);
    for (int i = 0; i < 4; i++) nib(0, 0, 4'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule